// File: doc/BRIEF.md
# Skewed-Strobe Delay-Test Sequencer

This block runs a delay test on a fast device from a single rated-speed clock, while vectors and output checks move only at a slow test rate. Each vector is held on the device inputs for one test period of N rated cycles. The device flip-flops get a clock enable in every rated cycle of that period. An output strobe falls on cycle k of the period, and the captured device outputs are compared with expected bits under a care mask on that strobe.

The whole vector set is applied N times. The strobe skew k is 1 on the first pass and rises by one on each later pass until it reaches N. A slow observation rate can therefore still catch paths that settle late within a single rated period. Vectors come from a ready/valid source, which reads the pass-relative index `vec_idx` and replays the same set on every pass. The block counts mismatches with a saturating counter and records the skew of the first failing strobe.

Sequencer states: IDLE (waiting for start), LAUNCH (requesting a vector outside a period), WAIT_STROBE (period cycles before the strobe), SAMPLE (the strobe cycle), NEXT_VECTOR (period cycles after the strobe), NEXT_PASS (one cycle that advances the skew) and DONE. Transitions:
- IDLE or DONE go to LAUNCH on start, or to DONE if the vector count is zero.
- LAUNCH goes on a handshake to SAMPLE when k=1, otherwise to WAIT_STROBE.
- WAIT_STROBE goes to SAMPLE when the next cycle index equals k.
- SAMPLE and NEXT_VECTOR go to NEXT_VECTOR inside the period. At the end of the period they go to the first period state of the next vector on a handshake, to LAUNCH when the source stalls, to NEXT_PASS after the last vector of a pass, or to DONE after the last pass.
- NEXT_PASS goes to LAUNCH.

Top module: `skew_strobe_seq`

## Requirements
- R1: After synchronous reset these outputs are all low or zero: `vec_ready`, `tclk_en`, `ff_clk_en`, `strobe`, `done`, `dut_in`, `miss_cnt` and `first_fail_valid`.
- R2: A start pulse in IDLE or DONE loads the factor N from `cfg_n` (0 is taken as 1, values above NMAX as NMAX) and the vector count. Start pulses and `cfg_n` changes during a run have no effect on that run.
- R3: A vector is taken on `vec_valid && vec_ready`. `vec_ready` is high in LAUNCH and in the last cycle of a period when more vectors remain in the pass. The taken vector appears on `dut_in` from the next cycle and stays unchanged until the next handshake.
- R4: If `vec_valid` is low while `vec_ready` is high, no period runs in the next cycle (`ff_clk_en` low), and no skew or vector counter advances.
- R5: Each period is N consecutive cycles with `ff_clk_en` high. `tclk_en` is high only in the first of these cycles.
- R6: `strobe` is high in exactly one cycle per period: cycle k, counting the `tclk_en` cycle as 1.
- R7: The skew output `skew` is k=1 on the first pass and increases by one per pass up to N. The run therefore holds N×V periods and N×N×V flip-flop clock cycles for V vectors.
- R8: On each strobe, a mismatch is any bit where `dut_obs` differs from the expected bits while the mask bit is 1. `miss_cnt` counts mismatching strobes and saturates at 2^MISS_W−1 (15 by default).
- R9: `first_fail_valid` is set on the first mismatching strobe of a run, and `first_fail_pass` then holds that strobe's skew k.
- R10: After the last strobe of pass N, `done` goes high and stays high until the next start. That start clears the mismatch count and the first-failure record.
- R11: A start with a vector count of zero goes straight to DONE without requesting any vector.
- R12: With N=1 every rated cycle is a period. Each period is also the strobe cycle, so the run is an ordinary at-speed test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rated-speed clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken in IDLE or DONE |
| cfg_n | input | N_W | Speed-reduction factor N |
| cfg_vcount | input | VC_W | Vectors per pass |
| vec_valid | input | 1 | Source holds a vector |
| vec_ready | output | 1 | Sequencer accepts a vector |
| vec_idx | output | VC_W | Index within the pass of the next vector to fetch |
| vec_drive | input | W | Input stimulus of the offered vector |
| vec_expect | input | W | Expected device outputs |
| vec_mask | input | W | Care mask, 1 = compare |
| dut_in | output | W | Stimulus held on the device inputs |
| tclk_en | output | 1 | Slow test-clock enable, first cycle of a period |
| ff_clk_en | output | 1 | Device flip-flop clock enable |
| strobe | output | 1 | Output sampling strobe |
| skew | output | N_W | Current skew index k |
| dut_obs | input | W | Captured device outputs |
| miss_cnt | output | MISS_W | Saturating mismatch count |
| first_fail_valid | output | 1 | A mismatch has been seen in this run |
| first_fail_pass | output | N_W | Skew k of the first mismatch |
| done | output | 1 | Run complete |

## Verification
A handshake in cycle t puts the vector on `dut_in` and starts the period in cycle t+1. The strobe comes k−1 cycles after `tclk_en`, and the comparison of that strobe cycle's `dut_obs` shows in `miss_cnt` one cycle later. The bench works in a single process at each falling edge. It rebuilds the position within the period from `tclk_en` and `ff_clk_en`, and pops the expected skew from a scoreboard queue at each strobe. It drives `dut_obs` for the current cycle so that it is registered at the next rising edge. A stall is checked one cycle after the refused handshake. Counts and the first-failure record are read only once `done` is high, after the last update.

// File: rtl/skewseq_pkg.sv
package skewseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT_STROBE,
        ST_SAMPLE,
        ST_NEXT_VECTOR,
        ST_NEXT_PASS,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/skewseq_vec_hold.sv
module skewseq_vec_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] drv_in,
    input  logic [W-1:0] exp_in,
    input  logic [W-1:0] mask_in,
    output logic [W-1:0] drv_q,
    output logic [W-1:0] exp_q,
    output logic [W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q  <= '0;
            exp_q  <= '0;
            mask_q <= '0;
        end else if (load) begin
            drv_q  <= drv_in;
            exp_q  <= exp_in;
            mask_q <= mask_in;
        end
    end

    // R3: held stimulus only moves on a load
    a_r3_hold_until_load: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(drv_q) && $stable(exp_q) && $stable(mask_q));
endmodule

// File: rtl/skewseq_compare.sv
module skewseq_compare #(
    parameter int W      = 8,
    parameter int MISS_W = 4,
    parameter int K_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic [W-1:0]      obs,
    input  logic [W-1:0]      exp_bits,
    input  logic [W-1:0]      care,
    input  logic [K_W-1:0]    pass_k,
    output logic [MISS_W-1:0] miss_cnt,
    output logic              first_valid,
    output logic [K_W-1:0]    first_pass
);
    localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

    logic miss;
    assign miss = |((obs ^ exp_bits) & care);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            miss_cnt    <= '0;
            first_valid <= 1'b0;
            first_pass  <= '0;
        end else if (sample && miss) begin
            if (miss_cnt != MISS_MAX) miss_cnt <= miss_cnt + 1'b1;
            if (!first_valid) begin
                first_valid <= 1'b1;
                first_pass  <= pass_k;
            end
        end
    end

    // R8: a saturated count never wraps
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (miss_cnt == MISS_MAX && !clear) |=> miss_cnt == MISS_MAX);
    // R9: the first-failure record is frozen once set
    a_r9_first_frozen: assert property (@(posedge clk) disable iff (rst)
        (first_valid && !clear) |=> first_valid && $stable(first_pass));
endmodule

// File: rtl/skew_strobe_seq.sv
module skew_strobe_seq #(
    parameter int W      = 8,
    parameter int NMAX   = 16,
    parameter int VC_W   = 8,
    parameter int MISS_W = 4,
    localparam int N_W   = $clog2(NMAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [N_W-1:0]    cfg_n,
    input  logic [VC_W-1:0]   cfg_vcount,
    input  logic              vec_valid,
    output logic              vec_ready,
    output logic [VC_W-1:0]   vec_idx,
    input  logic [W-1:0]      vec_drive,
    input  logic [W-1:0]      vec_expect,
    input  logic [W-1:0]      vec_mask,
    output logic [W-1:0]      dut_in,
    output logic              tclk_en,
    output logic              ff_clk_en,
    output logic              strobe,
    output logic [N_W-1:0]    skew,
    input  logic [W-1:0]      dut_obs,
    output logic [MISS_W-1:0] miss_cnt,
    output logic              first_fail_valid,
    output logic [N_W-1:0]    first_fail_pass,
    output logic              done
);
    import skewseq_pkg::*;

    localparam logic [N_W-1:0] N_ONE = N_W'(1);
    localparam logic [N_W-1:0] N_TOP = N_W'(NMAX);

    seq_state_e        state, state_nx;
    logic [N_W-1:0]    n_reg, cyc, k_reg, n_clamped;
    logic [VC_W-1:0]   vcnt_reg, vidx;
    logic              idle_like, in_period, end_period, more_vecs, fire, take_start;
    logic [W-1:0]      exp_q, mask_q;
    seq_state_e        first_st;

    assign idle_like  = (state == ST_IDLE) || (state == ST_DONE);
    assign take_start = idle_like && start;
    assign in_period  = (state == ST_WAIT_STROBE) || (state == ST_SAMPLE)
                     || (state == ST_NEXT_VECTOR);
    assign end_period = (cyc == n_reg);
    assign more_vecs  = (vidx != vcnt_reg);
    assign first_st   = (k_reg == N_ONE) ? ST_SAMPLE : ST_WAIT_STROBE;
    assign n_clamped  = (cfg_n == '0) ? N_ONE : ((cfg_n > N_TOP) ? N_TOP : cfg_n);

    assign vec_ready = (state == ST_LAUNCH) || (in_period && end_period && more_vecs);
    assign fire      = vec_ready && vec_valid;

    // next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) state_nx = (cfg_vcount == '0) ? ST_DONE : ST_LAUNCH;
            end
            ST_LAUNCH: begin
                if (vec_valid) state_nx = first_st;
            end
            ST_WAIT_STROBE: begin
                if (cyc + N_ONE == k_reg) state_nx = ST_SAMPLE;
            end
            ST_SAMPLE, ST_NEXT_VECTOR: begin
                if (!end_period)     state_nx = ST_NEXT_VECTOR;
                else if (more_vecs)  state_nx = vec_valid ? first_st : ST_LAUNCH;
                else if (k_reg == n_reg) state_nx = ST_DONE;
                else                 state_nx = ST_NEXT_PASS;
            end
            ST_NEXT_PASS: state_nx = ST_LAUNCH;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            n_reg    <= N_ONE;
            vcnt_reg <= '0;
            cyc      <= '0;
            k_reg    <= '0;
            vidx     <= '0;
        end else begin
            state <= state_nx;
            if (take_start) begin
                n_reg    <= n_clamped;
                vcnt_reg <= cfg_vcount;
                k_reg    <= N_ONE;
                vidx     <= '0;
                cyc      <= '0;
            end else begin
                if (fire) begin
                    cyc  <= N_ONE;
                    vidx <= vidx + 1'b1;
                end else if (in_period && !end_period) begin
                    cyc <= cyc + N_ONE;
                end
                if (state == ST_NEXT_PASS) begin
                    k_reg <= k_reg + N_ONE;
                    vidx  <= '0;
                end
            end
        end
    end

    // output process
    always_comb begin
        tclk_en   = in_period && (cyc == N_ONE);
        ff_clk_en = in_period;
        strobe    = (state == ST_SAMPLE);
        done      = (state == ST_DONE);
        skew      = k_reg;
        vec_idx   = vidx;
    end

    skewseq_vec_hold #(.W(W)) i_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (fire),
        .drv_in  (vec_drive),
        .exp_in  (vec_expect),
        .mask_in (vec_mask),
        .drv_q   (dut_in),
        .exp_q   (exp_q),
        .mask_q  (mask_q)
    );

    skewseq_compare #(.W(W), .MISS_W(MISS_W), .K_W(N_W)) i_cmp (
        .clk         (clk),
        .rst         (rst),
        .clear       (take_start),
        .sample      (strobe),
        .obs         (dut_obs),
        .exp_bits    (exp_q),
        .care        (mask_q),
        .pass_k      (k_reg),
        .miss_cnt    (miss_cnt),
        .first_valid (first_fail_valid),
        .first_pass  (first_fail_pass)
    );

    // R5: period cycles are contiguous after the first one
    a_r5_no_gap: assert property (@(posedge clk) disable iff (rst)
        (ff_clk_en && !tclk_en) |-> $past(ff_clk_en));
    // R6: no second strobe before a new period begins
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (!strobe || tclk_en));
    // R4: a refused handshake outside a period keeps the device clock off
    a_r4_stall_quiet: assert property (@(posedge clk) disable iff (rst)
        (vec_ready && !vec_valid) |=> !ff_clk_en);
    // R7: skew stays within 1..N during a period
    a_r7_skew_range: assert property (@(posedge clk) disable iff (rst)
        ff_clk_en |-> (skew >= N_ONE && skew <= n_reg));
    // R2: configuration held while running
    a_r2_cfg_held: assert property (@(posedge clk) disable iff (rst)
        !idle_like |=> $stable(n_reg) && $stable(vcnt_reg));
    // R10: done holds until a start
    a_r10_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
endmodule

// File: tb/test_skew_strobe_seq.sv
module test_skew_strobe_seq;
    localparam int W = 8, NMAX = 16, VC_W = 8, MISS_W = 4;
    localparam int N_W = $clog2(NMAX + 1);

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [N_W-1:0] cfg_n = '0;
    logic [VC_W-1:0] cfg_vcount = '0;
    logic vec_valid = 1'b0, vec_ready;
    logic [VC_W-1:0] vec_idx;
    logic [W-1:0] vec_drive = '0, vec_expect = '0, vec_mask = '0, dut_in, dut_obs = '0;
    logic tclk_en, ff_clk_en, strobe, first_fail_valid, done;
    logic [N_W-1:0] skew, first_fail_pass;
    logic [MISS_W-1:0] miss_cnt;

    int checks = 0, failures = 0;
    int kq[$];
    int pos, ff_cnt, tclk_cnt, strobe_cnt, pv, cur_v, cur_settle, cur_bad;
    logic [W-1:0] cur_mask;
    bit stall_prev;

    always #4 clk = ~clk;

    skew_strobe_seq #(.W(W), .NMAX(NMAX), .VC_W(VC_W), .MISS_W(MISS_W)) i_skew_strobe_seq (
        .clk(clk), .rst(rst), .start(start), .cfg_n(cfg_n), .cfg_vcount(cfg_vcount),
        .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_idx(vec_idx),
        .vec_drive(vec_drive), .vec_expect(vec_expect), .vec_mask(vec_mask),
        .dut_in(dut_in), .tclk_en(tclk_en), .ff_clk_en(ff_clk_en), .strobe(strobe),
        .skew(skew), .dut_obs(dut_obs), .miss_cnt(miss_cnt),
        .first_fail_valid(first_fail_valid), .first_fail_pass(first_fail_pass), .done(done)
    );

    function automatic logic [W-1:0] drv_of(int i);
        return W'(i * 37 + 5);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: position in period, scoreboard pops, device output model
    task automatic mon_step();
        if (stall_prev) chk(!ff_clk_en, "R4 no period after refused handshake", ff_clk_en, 0);
        if (tclk_en) begin
            pos = 1; tclk_cnt++;
            chk(dut_in == drv_of(pv % cur_v), "R3 stimulus at period start", dut_in, drv_of(pv % cur_v));
            pv++;
        end else if (ff_clk_en) pos++;
        if (ff_clk_en) ff_cnt++;
        if (strobe) begin
            strobe_cnt++;
            if (kq.size() == 0) chk(1'b0, "R6 unexpected strobe", pos, 0);
            else begin
                int e = kq.pop_front();
                chk(pos == e, "R6 strobe position", pos, e);
                chk(int'(skew) == e, "R7 skew value", skew, e);
            end
        end
        if (ff_clk_en)
            dut_obs = (pos >= cur_settle && pos < cur_bad) ? (dut_in ^ 8'h5A) : ~(dut_in ^ 8'h5A);
    endtask

    task automatic run_test(string tag, int cfg, int n, int v, int settle, int bad,
                            logic [W-1:0] mask, int st_a, int st_b, int poke);
        int exp_miss = 0, exp_first = 0, cyc = 0;
        bit ready_seen = 0;
        for (int p = 1; p <= n; p++) begin
            for (int j = 0; j < v; j++) kq.push_back(p);
            if ((p < settle || p >= bad) && mask != '0) begin
                exp_miss += v;
                if (exp_first == 0 && v > 0) exp_first = p;
            end
        end
        if (exp_miss > 15) exp_miss = 15;
        pos = 0; ff_cnt = 0; tclk_cnt = 0; strobe_cnt = 0; pv = 0;
        cur_v = (v == 0) ? 1 : v; cur_settle = settle; cur_bad = bad; cur_mask = mask;
        stall_prev = 0;
        cfg_n = N_W'(cfg); cfg_vcount = VC_W'(v);
        forever begin
            @(negedge clk);
            mon_step();
            if (vec_ready) ready_seen = 1;
            start = (cyc == 0) || (poke > 0 && cyc == poke);
            if (poke > 0 && cyc == poke) cfg_n = N_W'(2);
            vec_valid = !(cyc >= st_a && cyc < st_b);
            vec_drive = drv_of(int'(vec_idx));
            vec_expect = drv_of(int'(vec_idx)) ^ 8'h5A;
            vec_mask = mask;
            stall_prev = vec_ready && !vec_valid;
            cyc++;
            if (done && cyc > 2) break;
            if (cyc > 20000) begin
                chk(1'b0, {"R10 run hung ", tag}, cyc, 0);
                break;
            end
        end
        start = 0;
        chk(ff_cnt == n * n * v, {"R7 ff clock cycles ", tag}, ff_cnt, n * n * v);
        chk(tclk_cnt == n * v, {"R5 test periods ", tag}, tclk_cnt, n * v);
        chk(strobe_cnt == n * v, {"R6 strobe count ", tag}, strobe_cnt, n * v);
        chk(kq.size() == 0, {"R7 pending skews ", tag}, kq.size(), 0);
        chk(int'(miss_cnt) == exp_miss, {"R8 mismatch count ", tag}, miss_cnt, exp_miss);
        chk(first_fail_valid == (exp_first != 0), {"R9 first-fail flag ", tag}, first_fail_valid, exp_first != 0);
        if (exp_first != 0)
            chk(int'(first_fail_pass) == exp_first, {"R9 first-fail pass ", tag}, first_fail_pass, exp_first);
        if (v == 0) chk(!ready_seen, "R11 no vector request", ready_seen, 0);
        repeat (4) @(negedge clk);
        chk(done == 1'b1, {"R10 done held ", tag}, done, 1);
        kq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!vec_ready && !tclk_en && !ff_clk_en && !strobe && !done, "R1 control outputs after reset",
            {vec_ready, tclk_en, ff_clk_en, strobe, done}, 0);
        chk(dut_in == '0 && miss_cnt == '0 && !first_fail_valid, "R1 data outputs after reset",
            int'(dut_in) + int'(miss_cnt), 0);
        run_test("n4",     4, 4, 3, 3, 99, 8'hFF, -1, -1, 0);
        run_test("sat",    4, 4, 6, 5, 99, 8'hFF, -1, -1, 0);
        run_test("R12 n1", 1, 1, 4, 1, 99, 8'hFF, -1, -1, 0);
        run_test("late",   4, 4, 2, 1, 3,  8'hFF, -1, -1, 0);
        run_test("stall",  5, 5, 3, 2, 99, 8'hFF, 10, 17, 0);
        run_test("mask",   3, 3, 2, 4, 99, 8'h00, -1, -1, 0);
        run_test("n0",     0, 1, 2, 1, 99, 8'hFF, -1, -1, 0);
        run_test("n20",    20, 16, 1, 1, 99, 8'hFF, -1, -1, 0);
        run_test("poke",   3, 3, 2, 3, 99, 8'hFF, -1, -1, 7);
        run_test("zero",   4, 4, 0, 1, 99, 8'hFF, -1, -1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 8);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule